// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block produces four pulse-width modulated outputs from one system clock. Four period generators each divide the clock by a programmable 16-bit value. Each division step is one tick, and 256 ticks form one output period. Each output channel has an 8-bit duty value and a 2-bit field that chooses which of the four generators times it. Several channels can therefore share one period while each keeps its own duty.

Software drives the block through a single-cycle register bus. A write is taken on the clock edge where the write strobe is high. Read data follows the word address combinationally. Channel enables and full-on overrides take effect at once. New period, duty and generator-choice values wait for the end of the current period of the generator concerned, so no cut-short or stretched pulse appears. A further register holds a 4-bit per-channel clock-source field; it is kept as storage only and does not change the outputs.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads zero except word 1, which reads 0x0000000F. Each register reads back what was written, masked to its defined bits: word 0 mask 0x00000F0F, word 1 mask 0x0000000F, words 2 to 5 mask 0x0000FFFF, words 6 to 9 mask 0x000003FF.
- R2: Word addresses are: 0 = channel control, 1 = clock-source storage, 2+g = period of generator g, 6+n = duty of channel n. Words 10 to 15 read zero and ignore writes.
- R3: Bit n of word 0 enables channel n. While that bit is clear, output n is low, whatever the other settings.
- R4: Bit 8+n of word 0 forces channel n high continuously while the channel is enabled, even when its generator is idle.
- R5: With a nonzero period value P on its generator and a duty value D (0 < D < 256), an enabled channel is high for D*P clocks and low for (256-D)*P clocks, starting each period high.
- R6: A period value of zero keeps its generator idle with its phase at zero, and an enabled, non-forced channel that selects an idle generator stays low.
- R7: Bits [9:8] of a channel's duty word choose which generator (0 to 3) times that channel. Bits [7:0] hold the duty value.
- R8: Writes to period, duty or generator choice take effect at the next period boundary of the affected generator. The pulse in progress finishes with the old values. Enable and force bits act on the clock after the write.
- R9: A duty value of 0 keeps the output low. A duty value of 255 gives a low time of exactly one tick (P clocks) per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_rdata | output | 32 | Read data for the addressed word |
| pwm_out | output | 4 | Channel outputs |

## Verification
On every cycle the assertions check three things. A disabled channel is never high, and an enabled, forced channel is never low. Each generator's phase moves only by one step on a tick, or back to zero at a boundary. An idle generator holds its phase at zero. The measured pulse shapes are shown only by the bench's scenarios: high and low lengths across random generator choices, periods and duties. So are the deferral of a duty change to the next boundary, the read-back masks and the duty extremes.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
    parameter int NCH     = 4;
    parameter int NGEN    = 4;
    parameter int PER_W   = 16;
    parameter int DUTY_W  = 8;
    parameter int ADDR_W  = 4;
    parameter int DATA_W  = 32;
    localparam int SEL_W   = $clog2(NGEN);
    localparam int FRC_LSB = 8;
    localparam int A_CTRL  = 0;
    localparam int A_CSRC  = 1;
    localparam int A_PER0  = 2;
    localparam int A_DUTY0 = A_PER0 + NGEN;

    typedef struct packed {
        logic [NCH-1:0]                 en;
        logic [NCH-1:0]                 frc;
        logic [NCH-1:0]                 csrc;
        logic [NGEN-1:0][PER_W-1:0]     per;
        logic [NCH-1:0][DUTY_W-1:0]     duty;
        logic [NCH-1:0][SEL_W-1:0]      sel;
    } regs_t;

    typedef struct packed {
        logic [PER_W-1:0]  act;
        logic [PER_W-1:0]  presc;
        logic [DUTY_W-1:0] phase;
    } gen_t;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic [SEL_W-1:0]  sel;
    } chan_t;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output regs_t             regs
);
    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTRL)) begin
            bus_rdata[NCH-1:0]         = r_q.en;
            bus_rdata[FRC_LSB +: NCH]  = r_q.frc;
            if (bus_we) begin
                r_d.en  = bus_wdata[NCH-1:0];
                r_d.frc = bus_wdata[FRC_LSB +: NCH];
            end
        end
        if (bus_addr == ADDR_W'(A_CSRC)) begin
            bus_rdata[NCH-1:0] = r_q.csrc;
            if (bus_we) r_d.csrc = bus_wdata[NCH-1:0];
        end
        for (int g = 0; g < NGEN; g++) begin
            if (bus_addr == ADDR_W'(A_PER0 + g)) begin
                bus_rdata[PER_W-1:0] = r_q.per[g];
                if (bus_we) r_d.per[g] = bus_wdata[PER_W-1:0];
            end
        end
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == ADDR_W'(A_DUTY0 + n)) begin
                bus_rdata[DUTY_W-1:0]      = r_q.duty[n];
                bus_rdata[DUTY_W +: SEL_W] = r_q.sel[n];
                if (bus_we) begin
                    r_d.duty[n] = bus_wdata[DUTY_W-1:0];
                    r_d.sel[n]  = bus_wdata[DUTY_W +: SEL_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.csrc <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;
endmodule

// File: rtl/pwm_quad_timebase.sv
module pwm_quad_timebase
    import pwm_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  per_cfg,
    output logic [DUTY_W-1:0] phase,
    output logic              tick,
    output logic              wrap,
    output logic              idle
);
    gen_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        idle  = (s_q.act == '0);
        tick  = !idle && (s_q.presc == s_q.act - 1'b1);
        wrap  = idle || (tick && (s_q.phase == '1));
        if (wrap) begin
            s_d.act   = per_cfg;
            s_d.presc = '0;
            s_d.phase = '0;
        end else if (tick) begin
            s_d.presc = '0;
            s_d.phase = s_q.phase + 1'b1;
        end else begin
            s_d.presc = s_q.presc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase = s_q.phase;
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
    import pwm_quad_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic                        frc,
    input  logic [DUTY_W-1:0]           duty_cfg,
    input  logic [SEL_W-1:0]            sel_cfg,
    input  logic [NGEN-1:0][DUTY_W-1:0] gen_phase,
    input  logic [NGEN-1:0]             gen_wrap,
    input  logic [NGEN-1:0]             gen_idle,
    output logic                        out
);
    chan_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (gen_wrap[c_q.sel]) begin
            c_d.duty = duty_cfg;
            c_d.sel  = sel_cfg;
        end
        out = en && (frc || (!gen_idle[c_q.sel] &&
                             (gen_phase[c_q.sel] < c_q.duty)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    regs_t                       regs;
    logic [NGEN-1:0][DUTY_W-1:0] gen_phase;
    logic [NGEN-1:0]             gen_tick;
    logic [NGEN-1:0]             gen_wrap;
    logic [NGEN-1:0]             gen_idle;

    pwm_quad_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .regs      (regs)
    );

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        pwm_quad_timebase u_tb (
            .clk     (clk),
            .rst_n   (rst_n),
            .per_cfg (regs.per[g]),
            .phase   (gen_phase[g]),
            .tick    (gen_tick[g]),
            .wrap    (gen_wrap[g]),
            .idle    (gen_idle[g])
        );
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pwm_quad_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (regs.en[n]),
            .frc       (regs.frc[n]),
            .duty_cfg  (regs.duty[n]),
            .sel_cfg   (regs.sel[n]),
            .gen_phase (gen_phase),
            .gen_wrap  (gen_wrap),
            .gen_idle  (gen_idle),
            .out       (pwm_out[n])
        );
    end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
    import pwm_quad_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic [NCH-1:0]              en,
    input logic [NCH-1:0]              frc,
    input logic [NCH-1:0]              pwm_out,
    input logic [NGEN-1:0][DUTY_W-1:0] gen_phase,
    input logic [NGEN-1:0]             gen_tick,
    input logic [NGEN-1:0]             gen_wrap,
    input logic [NGEN-1:0]             gen_idle
);
    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out & ~en) == '0);

    p_force_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & frc) & ~pwm_out) == '0);

    for (genvar g = 0; g < NGEN; g++) begin : g_a
        p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!gen_tick[g] && !gen_wrap[g]) |=> $stable(gen_phase[g]));

        p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_tick[g] && !gen_wrap[g]) |=>
                gen_phase[g] == DUTY_W'($past(gen_phase[g]) + 1'b1));

        p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            gen_idle[g] |-> (gen_phase[g] == '0 && !gen_tick[g]));
    end
endmodule

bind pwm_quad pwm_quad_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (regs.en),
    .frc       (regs.frc),
    .pwm_out   (pwm_out),
    .gen_phase (gen_phase),
    .gen_tick  (gen_tick),
    .gen_wrap  (gen_wrap),
    .gen_idle  (gen_idle)
);

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    localparam int LIMIT = 4000;

    always #4 clk = ~clk;

    pwm_quad dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic logic [31:0] read_mask(int a);
        if (a == 0) return 32'h0000_0F0F;
        if (a == 1) return 32'h0000_000F;
        if (a >= 2 && a <= 5) return 32'h0000_FFFF;
        if (a >= 6 && a <= 9) return 32'h0000_03FF;
        return 32'h0;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_addr = 4'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wait_lvl(int c, bit lvl, output int n);
        n = 0;
        while (pwm_out[c] !== lvl && n < LIMIT) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic measure(int c, output int hi, output int lo);
        int k;
        wait_lvl(c, 1'b0, k); wait_lvl(c, 1'b1, k);
        wait_lvl(c, 1'b0, k); wait_lvl(c, 1'b1, k);
        wait_lvl(c, 1'b0, hi); wait_lvl(c, 1'b1, lo);
    endtask

    task automatic count_high(int c, int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            if (pwm_out[c]) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] wv [16];
        int hi, lo, n, s;
        s = $urandom(32'h1d2c);
        do_reset();

        // R1 R2: reset values
        check("R3 reset out", pwm_out, 0);
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            check("R1 reset read", v, (a == 1) ? 32'hF : 32'h0);
        end
        // R1 R2: read-back masks, unused words
        for (int a = 0; a < 16; a++) begin
            wv[a] = $urandom;
            wr(a, wv[a]);
        end
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            check("R1 R2 readback", v, wv[a] & read_mask(a));
        end
        do_reset();

        // R5 R7: random generator choice, period and duty
        wr(0, 32'h0000_000F);
        for (int it = 0; it < 12; it++) begin
            int c, g, p, d;
            c = $urandom_range(0, 3);
            g = $urandom_range(0, 3);
            p = $urandom_range(1, 3);
            d = $urandom_range(1, 254);
            wr(2 + g, p);
            wr(6 + c, (g << 8) | d);
            measure(c, hi, lo);
            check("R5 R7 high time", hi, d * p);
            check("R5 R7 low time", lo, (256 - d) * p);
        end
        do_reset();

        // R8: duty change deferred to next boundary
        wr(0, 32'h1);
        wr(2, 2);
        wr(6, 100);
        measure(0, hi, lo);
        repeat (10) @(negedge clk);
        wr(6, 200);
        wait_lvl(0, 1'b0, n);
        check("R8 old duty kept", 12 + n, 200);
        wait_lvl(0, 1'b1, n);
        wait_lvl(0, 1'b0, n);
        check("R8 new duty applied", n, 400);

        // R9: duty extremes on generator 1, period 1
        wr(0, 32'h3);
        wr(3, 1);
        wr(7, (1 << 8) | 255);
        measure(1, hi, lo);
        check("R9 duty 255 high", hi, 255);
        check("R9 duty 255 low", lo, 1);
        wr(7, (1 << 8) | 0);
        repeat (300) @(negedge clk);
        count_high(1, 600, n);
        check("R9 duty 0 low", n, 0);

        // R6: idle generator 3 keeps channel 3 low
        wr(0, 32'hB);
        wr(9, (3 << 8) | 128);
        count_high(3, 600, n);
        check("R6 idle gen low", n, 0);

        // R4: force high at once, even with idle generator
        wr(0, 32'h080B);
        check("R4 force immediate", pwm_out[3], 1);
        count_high(3, 300, n);
        check("R4 force constant", n, 300);

        // R3: disable overrides force, takes effect at once
        wr(0, 32'h0803);
        check("R3 disabled low", pwm_out[3], 0);
        count_high(3, 300, n);
        check("R3 disabled stays low", n, 0);

        // R2: write to unused word leaves controls unchanged
        wr(12, 32'hFFFF_FFFF);
        rd(0, v);
        check("R2 unused write ignored", v, 32'h0803);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule